// File: doc/BRIEF.md
# Ripple-Chain Elastic FIFO

This block is a first-in/first-out buffer that holds up to sixteen 4-bit words. Storage is a chain of stages, each with one data word and a one-bit occupancy marker. A word written at the head stage moves one stage toward the tail on every clock in which the next stage is vacant. As a result, filled stages collect at the output end and vacancies drift back toward the input end. No read or write pointers exist. Every word passes through every stage, so a word written into an empty buffer takes a fixed number of clocks to reach the output.

A producer writes a word by raising `shiftIn` while `inReady` is high. A consumer removes the word at the tail by raising `shiftOut` while `outReady` is high. The data output is three-state and is released to high impedance when `outEn` is low. `mrst` empties the whole chain at once. All stage transfers in one clock are decided from the markers as they stood before that clock edge.

Top module: `bubble_fifo`

## Requirements
- R1: The buffer holds exactly 16 words of 4 bits. With shift-in held high and no shift-out, exactly 16 words are accepted, and `inReady` is low whenever 16 words are held.
- R2: While `mrst` is high, and after it is released, every stage is empty, `inReady` is 1 and `outReady` is 0.
- R3: A word is accepted on a clock edge only if `shiftIn` and `inReady` are both high at that edge. `shiftIn` while `inReady` is low changes nothing.
- R4: A word moves at most one stage per clock. A word written into an empty buffer raises `outReady` exactly 15 clocks after the edge that accepted it.
- R5: Words leave in the order they were accepted, with none lost or duplicated. While `outReady` is high and `outEn` is high, `dataOut` shows the oldest word held. When the buffer is empty, `outReady` is 0.
- R6: A shift-out is honoured when `outReady` is high, and it clears the tail marker on that edge. A word waiting in the stage next to the tail arrives one clock later, so `outReady` is low for one cycle in between.
- R7: `shiftOut` while `outReady` is low has no effect. A word still rippling toward the tail arrives on time and is not discarded.
- R8: When `outEn` is 0, `dataOut` is high impedance on all 4 bits. When `outEn` is 1, it drives the tail word.
- R9: `inReady` shows the head stage's vacancy. After a word is accepted, `inReady` is low for the next cycle and then rises once the word has moved on. A streaming producer therefore gets one word in every two clocks.
- R10: While `outReady` is high and no shift-out is made, `outReady` stays high and `dataOut` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all stages |
| mrst | input | 1 | Asynchronous active-high master reset; empties every stage |
| shiftIn | input | 1 | Write request for the word on `dataIn` |
| dataIn | input | 4 | Word to be written |
| inReady | output | 1 | High when the head stage is vacant |
| shiftOut | input | 1 | Remove request for the tail word |
| outReady | output | 1 | High when the tail stage holds a word |
| outEn | input | 1 | Drives `dataOut` when high; high impedance when low |
| dataOut | output | 4 | Tail word, three-state |

## Verification
The hardest case to reach is a shift-out that lands while the next word sits in the stage just behind the tail, because the held-back cycle appears only when the chain is packed. The bench first fills the buffer to capacity with a streaming producer, then pops once and samples `outReady` on each of the next two cycles. It also raises shift-out while a lone word is still travelling, to show that the early request is dropped without losing the word. Long random traffic then compares every cycle against a queue model, and each phase drains the buffer to catch any word that was lost or duplicated.

// File: rtl/bubble_fifo_pkg.sv
package bubble_fifo_pkg;
  // Strobes raised by the marker control for the word storage
  typedef struct packed {
    logic loadFirst;   // head stage captures dataIn this edge
    logic dropLast;    // tail word is consumed this edge
  } bffStrobes_t;
endpackage

// File: rtl/bubble_fifo_ctrl.sv
module bubble_fifo_ctrl
  import bubble_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              shiftIn,
  input  logic              shiftOut,
  output logic [DEPTH-1:1]  moveVec,
  output bffStrobes_t       strobes,
  output logic              inReady,
  output logic              outReady
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] mark;
  logic [DEPTH-1:0] markNext;

  always_comb begin
    strobes.loadFirst = shiftIn & ~mark[0];
    strobes.dropLast  = shiftOut & mark[LAST];
  end

  // a vacant stage pulls the word from a filled predecessor
  for (genvar i = 1; i < DEPTH; i++) begin : gMove
    assign moveVec[i] = mark[i-1] & ~mark[i];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gNext
    logic gain;
    logic lose;
    if (i == 0) begin : gHeadGain
      assign gain = strobes.loadFirst;
    end else begin : gBodyGain
      assign gain = moveVec[i];
    end
    if (i == LAST) begin : gTailLose
      assign lose = strobes.dropLast;
    end else begin : gBodyLose
      assign lose = moveVec[i+1];
    end
    assign markNext[i] = (mark[i] & ~lose) | gain;
  end

  always_ff @(posedge clk or posedge mrst) begin
    if (mrst) mark <= '0;
    else      mark <= markNext;
  end

  assign inReady  = ~mark[0];
  assign outReady = mark[LAST];

  // R2
  reset_flags_chk: assert property (@(posedge clk) disable iff (mrst)
    $fell(mrst) |-> (inReady && !outReady));

  // R5
  occupancy_conserved_chk: assert property (@(posedge clk) disable iff (mrst)
    1'b1 |=> ($countones(mark) == $countones($past(mark))
              + int'($past(strobes.loadFirst)) - int'($past(strobes.dropLast))));

  // R6
  tail_gap_chk: assert property (@(posedge clk) disable iff (mrst)
    strobes.dropLast |=> !outReady);

  // R7
  idle_pop_chk: assert property (@(posedge clk) disable iff (mrst)
    (shiftOut && !outReady) |=> ($countones(mark) >= $countones($past(mark))));

  // R10
  tail_hold_chk: assert property (@(posedge clk) disable iff (mrst)
    (outReady && !shiftOut) |=> outReady);

  // R4
  for (genvar i = 1; i < DEPTH; i++) begin : gAdvChk
    advance_chk: assert property (@(posedge clk) disable iff (mrst)
      (mark[i-1] && !mark[i]) |=> mark[i]);
  end
endmodule

// File: rtl/bubble_fifo_datapath.sv
module bubble_fifo_datapath
  import bubble_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic [WIDTH-1:0]  dataIn,
  input  logic [DEPTH-1:1]  moveVec,
  input  bffStrobes_t       strobes,
  output logic [WIDTH-1:0]  lastWord
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0][WIDTH-1:0] words;
  logic [DEPTH-1:0][WIDTH-1:0] srcVec;
  logic [DEPTH-1:0]            loadVec;

  for (genvar i = 0; i < DEPTH; i++) begin : gSrc
    if (i == 0) begin : gHead
      assign loadVec[i] = strobes.loadFirst;
      assign srcVec[i]  = dataIn;
    end else begin : gBody
      assign loadVec[i] = moveVec[i];
      assign srcVec[i]  = words[i-1];
    end
  end

  always_ff @(posedge clk or posedge mrst) begin
    if (mrst) begin
      words <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (loadVec[i]) words[i] <= srcVec[i];
      end
    end
  end

  assign lastWord = words[LAST];

  // R3
  head_capture_chk: assert property (@(posedge clk) disable iff (mrst)
    strobes.loadFirst |=> (words[0] == $past(dataIn)));

  // R10
  tail_stable_chk: assert property (@(posedge clk) disable iff (mrst)
    !moveVec[LAST] |=> $stable(lastWord));

  // R4
  for (genvar i = 1; i < DEPTH; i++) begin : gCopyChk
    word_copy_chk: assert property (@(posedge clk) disable iff (mrst)
      moveVec[i] |=> (words[i] == $past(words[i-1])));
  end
endmodule

// File: rtl/bubble_fifo.sv
module bubble_fifo
  import bubble_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              shiftIn,
  input  logic [WIDTH-1:0]  dataIn,
  output logic              inReady,
  input  logic              shiftOut,
  output logic              outReady,
  input  logic              outEn,
  output logic [WIDTH-1:0]  dataOut
);
  logic [DEPTH-1:1] moveVec;
  bffStrobes_t      strobes;
  logic [WIDTH-1:0] lastWord;

  bubble_fifo_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk      (clk),
    .mrst     (mrst),
    .shiftIn  (shiftIn),
    .shiftOut (shiftOut),
    .moveVec  (moveVec),
    .strobes  (strobes),
    .inReady  (inReady),
    .outReady (outReady)
  );

  bubble_fifo_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uData (
    .clk      (clk),
    .mrst     (mrst),
    .dataIn   (dataIn),
    .moveVec  (moveVec),
    .strobes  (strobes),
    .lastWord (lastWord)
  );

  assign dataOut = outEn ? lastWord : {WIDTH{1'bz}};
endmodule

// File: tb/sim_bubble_fifo.sv
module sim_bubble_fifo;
  localparam int PERIOD = 10;
  localparam int CAP    = 16;

  logic       clk = 1'b0;
  logic       mrst;
  logic       shiftIn;
  logic       shiftOut;
  logic       outEn;
  logic [3:0] dataIn;
  logic       inReady;
  logic       outReady;
  wire  [3:0] dataOut;

  int checks = 0;
  int errors = 0;
  logic [3:0] q[$];
  logic lastAccepted;

  bubble_fifo u0 (
    .clk(clk), .mrst(mrst), .shiftIn(shiftIn), .dataIn(dataIn),
    .inReady(inReady), .shiftOut(shiftOut), .outReady(outReady),
    .outEn(outEn), .dataOut(dataOut)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic perClock();
    if (outReady) begin
      check(q.size() > 0, "R5 outReady with empty model", q.size(), 1);
      if (outEn && q.size() > 0)
        check(dataOut === q[0], "R5 order", int'(dataOut), int'(q[0]));
    end
    if (q.size() == 0) check(!outReady, "R5 empty flag", int'(outReady), 0);
    if (q.size() == CAP) check(!inReady, "R1 full flag", int'(inReady), 0);
  endtask

  task automatic step(input logic si, input logic [3:0] d, input logic so);
    logic acIn, acOut;
    acIn  = si && inReady;
    acOut = so && outReady;
    shiftIn = si; dataIn = d; shiftOut = so;
    @(posedge clk);
    if (acOut) void'(q.pop_front());
    if (acIn) q.push_back(d);
    lastAccepted = acIn;
    @(negedge clk);
    shiftIn = 1'b0; shiftOut = 1'b0;
    perClock();
  endtask

  task automatic drain(output int popped);
    popped = 0;
    for (int k = 0; k < 400 && q.size() > 0; k++) begin
      if (outReady) popped++;
      step(1'b0, 4'h0, 1'b1);
    end
    for (int k = 0; k < 20; k++) step(1'b0, 4'h0, 1'b0);
    check(q.size() == 0 && !outReady, "R5 drained", q.size(), 0);
    check(inReady, "R5 head free after drain", int'(inReady), 1);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int first, n, accepted, got;
    logic [3:0] nextWord;
    mrst = 1'b1; shiftIn = 1'b0; shiftOut = 1'b0; outEn = 1'b1; dataIn = 4'h0;
    repeat (3) @(negedge clk);
    check(inReady && !outReady, "R2 during reset", int'({inReady, outReady}), 2);
    mrst = 1'b0;
    @(negedge clk);
    check(inReady == 1'b1, "R2 inReady", int'(inReady), 1);
    check(outReady == 1'b0, "R2 outReady", int'(outReady), 0);

    // R4 latency and R9 head flag, R3 ignored second write
    step(1'b1, 4'hA, 1'b0);
    check(!inReady, "R9 head busy", int'(inReady), 0);
    step(1'b1, 4'h7, 1'b0);
    check(!lastAccepted, "R3 write while busy ignored", int'(lastAccepted), 0);
    check(inReady, "R9 head free again", int'(inReady), 1);
    first = 1;
    for (int k = 2; k <= 20; k++) begin
      if (!outReady) begin
        step(1'b0, 4'h0, 1'b0);
        if (outReady) first = k;
      end
    end
    check(first == 15, "R4 latency", first, 15);

    // R10 hold, R8 three-state
    repeat (5) step(1'b0, 4'h0, 1'b0);
    check(outReady && dataOut === 4'hA, "R10 hold", int'(dataOut), 10);
    outEn = 1'b0;
    #1;
    check(dataOut === 4'bzzzz, "R8 released", int'(dataOut === 4'bzzzz), 1);
    outEn = 1'b1;
    #1;
    check(dataOut === 4'hA, "R8 driven", int'(dataOut), 10);
    drain(got);
    check(got == 1, "R3 one word stored", got, 1);

    // R7 early shift-out while word travels
    step(1'b1, 4'h5, 1'b0);
    first = 0;
    for (int k = 1; k <= 20; k++) begin
      if (first == 0) begin
        step(1'b0, 4'h0, (k == 5) || (k == 10));
        if (outReady) first = k;
      end
    end
    check(first == 15, "R7 word not lost", first, 15);
    check(dataOut === 4'h5, "R7 word value", int'(dataOut), 5);
    drain(got);

    // R1 fill, R6 held-back word
    accepted = 0;
    for (int k = 0; k < 60; k++) begin
      step(1'b1, 4'(k), 1'b0);
      if (lastAccepted) accepted++;
    end
    check(accepted == CAP, "R1 capacity", accepted, CAP);
    check(!inReady, "R1 full", int'(inReady), 0);
    nextWord = q[1];
    step(1'b0, 4'h0, 1'b1);
    check(!outReady, "R6 gap after pop", int'(outReady), 0);
    step(1'b0, 4'h0, 1'b0);
    check(outReady && dataOut === nextWord, "R6 next word arrives", int'(dataOut), int'(nextWord));
    drain(got);
    check(got == CAP - 1, "R5 remaining count", got, CAP - 1);

    // R2 mid-run reset
    repeat (6) step(1'b1, 4'h3, 1'b0);
    mrst = 1'b1;
    @(negedge clk);
    q.delete();
    mrst = 1'b0;
    @(negedge clk);
    check(inReady && !outReady, "R2 mid-run reset", int'({inReady, outReady}), 2);

    // R5 random traffic
    for (int k = 0; k < 4000; k++) begin
      n = (k / 500) % 3;
      step(1'($urandom % 2), 4'($urandom), 1'(($urandom % 4) < (n + 1)));
    end
    drain(got);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule